// File: doc/BRIEF.md
# Multiple Header Recording Error Log

This block keeps the logging side of an advanced error reporting capability. It holds a first-error pointer, a four-dword header log, a four-dword prefix log and a flag that says whether the prefix log is in use. When multiple header recording is enabled, errors that arrive while the current first error is still pending are not lost. They wait in a small queue of complete error records. Each time software clears the status bit of the current first error, the oldest waiting record moves into the log.

Log requests carry a one-hot status vector, header and prefix words and their qualifiers. Software write-one-to-clear accesses to the uncorrectable status register arrive as a write strobe together with the register value that results from the write. The block returns the log contents. It also returns a mask of status bits that the surrounding register must set again, so queued errors stay visible and a premature clear is undone. An overflow pulse reports that a request was dropped.

Control is an occupancy state machine with three states. `ST_IDLE` means the queue is empty, `ST_BACKLOG` means it is partly filled and `ST_FULL` means every slot is taken. The actions are:
- LOG: direct load.
- QUEUE: push. IDLE goes to BACKLOG, or to FULL when the depth is one. BACKLOG goes to FULL on the last free slot.
- DROP: overflow while in FULL. The state does not change.
- POP: replay. FULL goes to BACKLOG. BACKLOG goes to IDLE on the last entry.
- CLEAR: the log is wiped.
- RESTORE: status bits are re-asserted.
- FLUSH: BACKLOG or FULL goes to IDLE.

Top module: `mhr_error_log`

## Requirements
- R1: After reset, every output is zero: `fep_ptr`, `pfx_flag`, `hdr_log`, `pfx_log`, `reassert_bits` and `overflow`. The queue is empty.
- R2: When a request is logged directly, `fep_ptr` becomes the bit index of the lowest set bit of `log_status`. A direct log happens when `mhr_en` is 0, or when `uncor_sts[fep_ptr]` is 0.
- R3: Dword k of `hdr_log` (bits 32k+31..32k) is dword k of `log_hdr` with its four bytes reversed. It is all zeros when `log_hdr_valid` is 0.
- R4: `pfx_log` holds the byte-reversed prefix dwords and `pfx_flag` is 1 only when `log_pfx_present` and `pfx_supported` are both 1 at load time. Otherwise both are zero.
- R5: With `mhr_en` = 1 and `uncor_sts[fep_ptr]` = 1, a request is appended to the queue and the log outputs stay unchanged.
- R6: A request that would be queued while DEPTH entries are already waiting is dropped. `overflow` is then 1 for exactly one cycle.
- R7: When `sts_wr` arrives, `uncor_sts[fep_ptr]` is 0, `mhr_en` is 1 and the queue is non-empty, the oldest entry is loaded into the log (first in, first out). `reassert_bits` then carries the OR of the status vectors of every entry queued before the pop.
- R8: When `sts_wr` arrives with `uncor_sts[fep_ptr]` = 0, and the queue is empty or `mhr_en` is 0, the pointer, the flag and both logs are cleared to zero.
- R9: When `sts_wr` arrives with `uncor_sts[fep_ptr]` = 1 and `mhr_en` = 1, `reassert_bits` carries the OR of all queued status vectors and the log stays unchanged.
- R10: When `sts_wr` arrives with `uncor_sts[fep_ptr]` = 1 and `mhr_en` = 0, the queue is emptied. A later clear of the first-error bit then clears the log instead of replaying anything.
- R11: A `log_req` in the same cycle as `sts_wr` is ignored. It is neither logged nor queued, and it raises no overflow.
- R12: Every output changes on the clock edge that samples the causing input. `reassert_bits` and `overflow` are single-cycle pulses that return to zero on the next edge without a new cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mhr_en | input | 1 | Multiple header recording enable |
| pfx_supported | input | 1 | End-to-end prefixes are supported |
| log_req | input | 1 | Log request strobe |
| log_status | input | STAT_W | One-hot status of the new error |
| log_hdr_valid | input | 1 | Header words are valid |
| log_pfx_present | input | 1 | Prefix words are present |
| log_hdr | input | 128 | Header dwords, dword 0 in bits 31..0 |
| log_pfx | input | 128 | Prefix dwords, dword 0 in bits 31..0 |
| sts_wr | input | 1 | Software write to the uncorrectable status register |
| uncor_sts | input | STAT_W | Current uncorrectable status register value |
| fep_ptr | output | $clog2(STAT_W) | First-error pointer |
| pfx_flag | output | 1 | Prefix log valid |
| hdr_log | output | 128 | Header log register contents |
| pfx_log | output | 128 | Prefix log register contents |
| reassert_bits | output | STAT_W | Status bits to set again (one-cycle pulse) |
| overflow | output | 1 | Request dropped on a full queue (one-cycle pulse) |

## Verification
All results are registered once. A request or status write sampled on one rising edge shows its effect on the log registers, the re-assert mask and the overflow pulse on the outputs right after that same edge, and the pulses drop one edge later. The bench changes inputs on falling edges, so each input is held across exactly one rising edge. The reference model of pointer, logs, queue and pulses advances on the rising edge, and the outputs are compared with the model on the following falling edge. Directed checks are read at that same falling edge, and the pulse-return checks are read one falling edge later.

// File: rtl/mhr_log_pkg.sv
package mhr_log_pkg;

    localparam int LOG_WORDS = 4;
    localparam int WORD_W    = 32;
    localparam int QUAD_W    = LOG_WORDS * WORD_W;

    typedef logic [QUAD_W-1:0] quad_t;

    // queue occupancy states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BACKLOG = 2'd1,
        ST_FULL    = 2'd2
    } occ_e;

    // action chosen for the current cycle
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_LOG     = 3'd1,
        ACT_QUEUE   = 3'd2,
        ACT_DROP    = 3'd3,
        ACT_POP     = 3'd4,
        ACT_CLEAR   = 3'd5,
        ACT_RESTORE = 3'd6,
        ACT_FLUSH   = 3'd7
    } act_e;

    function automatic logic [WORD_W-1:0] swap_word(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/mhr_log_fifo.sv
module mhr_log_fifo
    import mhr_log_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [STAT_W-1:0] in_sts,
    input  logic              in_hv,
    input  logic              in_pp,
    input  quad_t             in_hdr,
    input  quad_t             in_pfx,
    output logic [STAT_W-1:0] head_sts,
    output logic              head_hv,
    output logic              head_pp,
    output quad_t             head_hdr,
    output quad_t             head_pfx,
    output logic [STAT_W-1:0] any_sts,
    output logic [CNT_W-1:0]  count
);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DEPTH-1:0]  slot_vld;
    logic [STAT_W-1:0] sts_mem [DEPTH];
    logic              hv_mem  [DEPTH];
    logic              pp_mem  [DEPTH];
    quad_t             hdr_mem [DEPTH];
    quad_t             pfx_mem [DEPTH];
    logic [STAT_W-1:0] masked  [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // pointers, occupancy and per-slot valid flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            slot_vld <= '0;
        end else if (flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            slot_vld <= '0;
        end else if (push) begin
            wr_ptr           <= bump(wr_ptr);
            count            <= count + CNT_W'(1);
            slot_vld[wr_ptr] <= 1'b1;
        end else if (pop) begin
            rd_ptr           <= bump(rd_ptr);
            count            <= count - CNT_W'(1);
            slot_vld[rd_ptr] <= 1'b0;
        end
    end

    // record storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sts_mem[i] <= '0;
                hv_mem[i]  <= 1'b0;
                pp_mem[i]  <= 1'b0;
                hdr_mem[i] <= '0;
                pfx_mem[i] <= '0;
            end
        end else if (push && !flush) begin
            sts_mem[wr_ptr] <= in_sts;
            hv_mem[wr_ptr]  <= in_hv;
            pp_mem[wr_ptr]  <= in_pp;
            hdr_mem[wr_ptr] <= in_hdr;
            pfx_mem[wr_ptr] <= in_pfx;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign masked[i] = slot_vld[i] ? sts_mem[i] : '0;
    end

    always_comb begin
        any_sts = '0;
        for (int i = 0; i < DEPTH; i++) begin
            any_sts = any_sts | masked[i];
        end
    end

    assign head_sts = sts_mem[rd_ptr];
    assign head_hv  = hv_mem[rd_ptr];
    assign head_pp  = pp_mem[rd_ptr];
    assign head_hdr = hdr_mem[rd_ptr];
    assign head_pfx = pfx_mem[rd_ptr];

endmodule

// File: rtl/mhr_log_regs.sv
module mhr_log_regs
    import mhr_log_pkg::*;
#(
    parameter int STAT_W = 32,
    localparam int PTR_W = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [STAT_W-1:0] ld_sts,
    input  logic              ld_hv,
    input  logic              ld_pp,
    input  quad_t             ld_hdr,
    input  quad_t             ld_pfx,
    input  logic              pfx_supported,
    output logic [PTR_W-1:0]  fep_ptr,
    output logic              pfx_flag,
    output quad_t             hdr_log,
    output quad_t             pfx_log
);

    quad_t hdr_sw;
    quad_t pfx_sw;

    function automatic logic [PTR_W-1:0] low_index(input logic [STAT_W-1:0] s);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (s[i]) r = PTR_W'(i);
        end
        return r;
    endfunction

    for (genvar w = 0; w < LOG_WORDS; w++) begin : g_word
        assign hdr_sw[w*WORD_W +: WORD_W] = swap_word(ld_hdr[w*WORD_W +: WORD_W]);
        assign pfx_sw[w*WORD_W +: WORD_W] = swap_word(ld_pfx[w*WORD_W +: WORD_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fep_ptr  <= '0;
            pfx_flag <= 1'b0;
            hdr_log  <= '0;
            pfx_log  <= '0;
        end else if (load) begin
            fep_ptr <= low_index(ld_sts);
            hdr_log <= ld_hv ? hdr_sw : '0;
            if (ld_pp && pfx_supported) begin
                pfx_log  <= pfx_sw;
                pfx_flag <= 1'b1;
            end else begin
                pfx_log  <= '0;
                pfx_flag <= 1'b0;
            end
        end else if (clear) begin
            fep_ptr  <= '0;
            pfx_flag <= 1'b0;
            hdr_log  <= '0;
            pfx_log  <= '0;
        end
    end

endmodule

// File: rtl/mhr_log_ctrl.sv
module mhr_log_ctrl
    import mhr_log_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(STAT_W),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_req,
    input  logic              sts_wr,
    input  logic              mhr_en,
    input  logic [STAT_W-1:0] uncor_sts,
    input  logic [PTR_W-1:0]  fep_ptr,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [STAT_W-1:0] fifo_any_sts,
    output act_e              act,
    output occ_e              state,
    output logic              overflow,
    output logic [STAT_W-1:0] reassert_bits
);

    occ_e nxt;
    logic fep_set;
    logic is_full;
    logic has_backlog;

    assign fep_set     = uncor_sts[fep_ptr];
    assign is_full     = (state == ST_FULL);
    assign has_backlog = (state != ST_IDLE);

    // action selection: a status write wins over a log request
    always_comb begin
        act = ACT_NONE;
        if (sts_wr) begin
            if (!fep_set) begin
                act = (mhr_en && has_backlog) ? ACT_POP : ACT_CLEAR;
            end else begin
                act = mhr_en ? ACT_RESTORE : ACT_FLUSH;
            end
        end else if (log_req) begin
            if (mhr_en && fep_set) begin
                act = is_full ? ACT_DROP : ACT_QUEUE;
            end else begin
                act = ACT_LOG;
            end
        end
    end

    // occupancy transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (act == ACT_QUEUE) nxt = (DEPTH == 1) ? ST_FULL : ST_BACKLOG;
            end
            ST_BACKLOG: begin
                if (act == ACT_QUEUE) begin
                    nxt = (fifo_count == CNT_W'(DEPTH - 1)) ? ST_FULL : ST_BACKLOG;
                end else if (act == ACT_POP) begin
                    nxt = (fifo_count == CNT_W'(1)) ? ST_IDLE : ST_BACKLOG;
                end else if (act == ACT_FLUSH) begin
                    nxt = ST_IDLE;
                end
            end
            ST_FULL: begin
                if (act == ACT_POP) begin
                    nxt = (DEPTH == 1) ? ST_IDLE : ST_BACKLOG;
                end else if (act == ACT_FLUSH) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow      <= 1'b0;
            reassert_bits <= '0;
        end else begin
            overflow      <= (act == ACT_DROP);
            reassert_bits <= (act == ACT_POP || act == ACT_RESTORE) ? fifo_any_sts : '0;
        end
    end

endmodule

// File: rtl/mhr_error_log.sv
module mhr_error_log
    import mhr_log_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(STAT_W),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mhr_en,
    input  logic              pfx_supported,
    input  logic              log_req,
    input  logic [STAT_W-1:0] log_status,
    input  logic              log_hdr_valid,
    input  logic              log_pfx_present,
    input  logic [QUAD_W-1:0] log_hdr,
    input  logic [QUAD_W-1:0] log_pfx,
    input  logic              sts_wr,
    input  logic [STAT_W-1:0] uncor_sts,
    output logic [PTR_W-1:0]  fep_ptr,
    output logic              pfx_flag,
    output logic [QUAD_W-1:0] hdr_log,
    output logic [QUAD_W-1:0] pfx_log,
    output logic [STAT_W-1:0] reassert_bits,
    output logic              overflow
);

    act_e              act;
    occ_e              state;
    logic [CNT_W-1:0]  fifo_count;
    logic [STAT_W-1:0] fifo_any;
    logic [STAT_W-1:0] head_sts;
    logic              head_hv;
    logic              head_pp;
    quad_t             head_hdr;
    quad_t             head_pfx;

    logic              from_queue;
    logic [STAT_W-1:0] ld_sts;
    logic              ld_hv;
    logic              ld_pp;
    quad_t             ld_hdr;
    quad_t             ld_pfx;

    mhr_log_ctrl #(.STAT_W(STAT_W), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .log_req       (log_req),
        .sts_wr        (sts_wr),
        .mhr_en        (mhr_en),
        .uncor_sts     (uncor_sts),
        .fep_ptr       (fep_ptr),
        .fifo_count    (fifo_count),
        .fifo_any_sts  (fifo_any),
        .act           (act),
        .state         (state),
        .overflow      (overflow),
        .reassert_bits (reassert_bits)
    );

    mhr_log_fifo #(.STAT_W(STAT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (act == ACT_QUEUE),
        .pop      (act == ACT_POP),
        .flush    (act == ACT_FLUSH),
        .in_sts   (log_status),
        .in_hv    (log_hdr_valid),
        .in_pp    (log_pfx_present),
        .in_hdr   (log_hdr),
        .in_pfx   (log_pfx),
        .head_sts (head_sts),
        .head_hv  (head_hv),
        .head_pp  (head_pp),
        .head_hdr (head_hdr),
        .head_pfx (head_pfx),
        .any_sts  (fifo_any),
        .count    (fifo_count)
    );

    assign from_queue = (act == ACT_POP);
    assign ld_sts = from_queue ? head_sts : log_status;
    assign ld_hv  = from_queue ? head_hv  : log_hdr_valid;
    assign ld_pp  = from_queue ? head_pp  : log_pfx_present;
    assign ld_hdr = from_queue ? head_hdr : log_hdr;
    assign ld_pfx = from_queue ? head_pfx : log_pfx;

    mhr_log_regs #(.STAT_W(STAT_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (act == ACT_LOG || act == ACT_POP),
        .clear         (act == ACT_CLEAR),
        .ld_sts        (ld_sts),
        .ld_hv         (ld_hv),
        .ld_pp         (ld_pp),
        .ld_hdr        (ld_hdr),
        .ld_pfx        (ld_pfx),
        .pfx_supported (pfx_supported),
        .fep_ptr       (fep_ptr),
        .pfx_flag      (pfx_flag),
        .hdr_log       (hdr_log),
        .pfx_log       (pfx_log)
    );

endmodule

// File: rtl/mhr_error_log_chk.sv
module mhr_error_log_chk #(
    parameter int STAT_W = 32,
    localparam int PTR_W = $clog2(STAT_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mhr_en,
    input logic              pfx_supported,
    input logic              log_req,
    input logic [STAT_W-1:0] log_status,
    input logic              sts_wr,
    input logic [STAT_W-1:0] uncor_sts,
    input logic [PTR_W-1:0]  fep_ptr,
    input logic              pfx_flag,
    input logic [127:0]      hdr_log,
    input logic [127:0]      pfx_log,
    input logic [STAT_W-1:0] reassert_bits,
    input logic              overflow
);

    logic              direct_q;
    logic [STAT_W-1:0] sts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            direct_q <= 1'b0;
            sts_q    <= '0;
        end else begin
            direct_q <= log_req && !sts_wr && !(mhr_en && uncor_sts[fep_ptr]);
            sts_q    <= log_status;
        end
    end

    p_direct_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        direct_q |-> sts_q[fep_ptr]);

    p_pfx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfx_flag) |-> $past(pfx_supported));

    p_queue_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (log_req && !sts_wr && mhr_en && uncor_sts[fep_ptr])
        |=> ($stable(hdr_log) && $stable(pfx_log) && $stable(fep_ptr) && $stable(pfx_flag)));

    p_overflow_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(log_req) && !$past(sts_wr) && $past(mhr_en)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !mhr_en && !uncor_sts[fep_ptr])
        |=> (hdr_log == '0 && pfx_log == '0 && fep_ptr == '0 && !pfx_flag));

    p_reassert_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|reassert_bits) |-> $past(sts_wr));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && log_req) |=> !overflow);

endmodule

bind mhr_error_log mhr_error_log_chk #(.STAT_W(STAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mhr_en        (mhr_en),
    .pfx_supported (pfx_supported),
    .log_req       (log_req),
    .log_status    (log_status),
    .sts_wr        (sts_wr),
    .uncor_sts     (uncor_sts),
    .fep_ptr       (fep_ptr),
    .pfx_flag      (pfx_flag),
    .hdr_log       (hdr_log),
    .pfx_log       (pfx_log),
    .reassert_bits (reassert_bits),
    .overflow      (overflow)
);

// File: tb/tb_mhr_error_log.sv
module tb_mhr_error_log;

    localparam int STAT_W = 32;
    localparam int DEPTH  = 4;
    localparam int PTR_W  = $clog2(STAT_W);

    typedef struct {
        logic [STAT_W-1:0] sts;
        bit                hv;
        bit                pp;
        logic [127:0]      hdr;
        logic [127:0]      pfx;
    } rec_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mhr_en = 1'b0;
    logic              pfx_supported = 1'b0;
    logic              log_req = 1'b0;
    logic [STAT_W-1:0] log_status = '0;
    logic              log_hdr_valid = 1'b0;
    logic              log_pfx_present = 1'b0;
    logic [127:0]      log_hdr = '0;
    logic [127:0]      log_pfx = '0;
    logic              sts_wr = 1'b0;
    logic [STAT_W-1:0] uncor_sts = '0;
    logic [PTR_W-1:0]  fep_ptr;
    logic              pfx_flag;
    logic [127:0]      hdr_log;
    logic [127:0]      pfx_log;
    logic [STAT_W-1:0] reassert_bits;
    logic              overflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    rec_t              mq[$];
    int                m_ptr = 0;
    bit                m_flag = 0;
    logic [127:0]      m_hdr = '0;
    logic [127:0]      m_pfx = '0;
    logic [STAT_W-1:0] m_reas = '0;
    bit                m_ovf = 0;

    always #5 clk = ~clk;

    mhr_error_log #(.STAT_W(STAT_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .pfx_supported(pfx_supported),
        .log_req(log_req), .log_status(log_status), .log_hdr_valid(log_hdr_valid),
        .log_pfx_present(log_pfx_present), .log_hdr(log_hdr), .log_pfx(log_pfx),
        .sts_wr(sts_wr), .uncor_sts(uncor_sts), .fep_ptr(fep_ptr), .pfx_flag(pfx_flag),
        .hdr_log(hdr_log), .pfx_log(pfx_log), .reassert_bits(reassert_bits),
        .overflow(overflow)
    );

    function automatic logic [127:0] rev_quad(input logic [127:0] q);
        logic [127:0] r;
        for (int w = 0; w < 4; w++) begin
            for (int b = 0; b < 4; b++) begin
                r[w*32 + b*8 +: 8] = q[w*32 + (3-b)*8 +: 8];
            end
        end
        return r;
    endfunction

    function automatic int lowest(input logic [STAT_W-1:0] s);
        for (int i = 0; i < STAT_W; i++) if (s[i]) return i;
        return 0;
    endfunction

    task automatic model_load(input rec_t r);
        m_ptr = lowest(r.sts);
        m_hdr = r.hv ? rev_quad(r.hdr) : '0;
        if (r.pp && pfx_supported) begin
            m_pfx = rev_quad(r.pfx); m_flag = 1;
        end else begin
            m_pfx = '0; m_flag = 0;
        end
    endtask

    function automatic logic [STAT_W-1:0] queued_or();
        logic [STAT_W-1:0] acc = '0;
        foreach (mq[i]) acc |= mq[i].sts;
        return acc;
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_ptr = 0; m_flag = 0; m_hdr = '0; m_pfx = '0;
            m_reas = '0; m_ovf = 0;
        end else begin
            rec_t nr;
            bit fs;
            fs = uncor_sts[m_ptr];
            m_reas = '0;
            m_ovf = 0;
            nr.sts = log_status; nr.hv = log_hdr_valid; nr.pp = log_pfx_present;
            nr.hdr = log_hdr; nr.pfx = log_pfx;
            if (sts_wr) begin
                if (!fs) begin
                    if (mhr_en && mq.size() > 0) begin
                        m_reas = queued_or();
                        model_load(mq.pop_front());
                    end else begin
                        m_ptr = 0; m_flag = 0; m_hdr = '0; m_pfx = '0;
                    end
                end else if (mhr_en) begin
                    m_reas = queued_or();
                end else begin
                    mq.delete();
                end
            end else if (log_req) begin
                if (mhr_en && fs) begin
                    if (mq.size() == DEPTH) m_ovf = 1;
                    else mq.push_back(nr);
                end else begin
                    model_load(nr);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 fep_ptr model", 128'(fep_ptr), 128'(m_ptr));
            chk("R3 hdr_log model", hdr_log, m_hdr);
            chk("R4 pfx_log model", pfx_log, m_pfx);
            chk("R4 pfx_flag model", 128'(pfx_flag), 128'(m_flag));
            chk("R7 reassert model", 128'(reassert_bits), 128'(m_reas));
            chk("R6 overflow model", 128'(overflow), 128'(m_ovf));
        end
    end

    task automatic req(input int bitn, input bit hv, input bit pp,
                       input logic [127:0] h, input logic [127:0] p);
        log_req = 1; log_status = STAT_W'(1) << bitn;
        log_hdr_valid = hv; log_pfx_present = pp; log_hdr = h; log_pfx = p;
        @(negedge clk);
        log_req = 0;
    endtask

    task automatic swr(input logic [STAT_W-1:0] s);
        uncor_sts = s; sts_wr = 1;
        @(negedge clk);
        sts_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] ha;
        ha = {32'h0D0E0F10, 32'h090A0B0C, 32'h05060708, 32'h11223344};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fep_ptr", 128'(fep_ptr), 0);
        chk("R1 hdr_log", hdr_log, 0);
        chk("R1 pfx_log|flag", {pfx_log[126:0], pfx_flag}, 0);
        chk("R1 pulses", 128'({reassert_bits, overflow}), 0);

        mhr_en = 1; pfx_supported = 1; uncor_sts = '0;
        req(5, 1, 1, ha, {4{32'hA1B2C3D4}});
        chk("R2 direct pointer", 128'(fep_ptr), 5);
        chk("R3 byte order dword0", 128'(hdr_log[31:0]), 128'(32'h44332211));
        chk("R4 prefix flag set", 128'(pfx_flag), 1);
        chk("R4 prefix swapped", 128'(pfx_log[31:0]), 128'(32'hD4C3B2A1));

        uncor_sts = 32'h0000_0020;
        req(9, 1, 0, {4{32'h99990009}}, '0);
        chk("R5 queued keeps ptr", 128'(fep_ptr), 5);
        chk("R5 queued keeps hdr", hdr_log, rev_quad(ha));
        req(12, 1, 1, {4{32'h12121212}}, {4{32'h0C0C0C0C}});
        req(3, 0, 0, {4{32'h33333333}}, '0);
        req(7, 1, 0, {4{32'h77777777}}, '0);
        req(20, 1, 0, {4{32'h20202020}}, '0);
        chk("R6 overflow on full", 128'(overflow), 1);
        @(negedge clk);
        chk("R12 overflow single pulse", 128'(overflow), 0);

        swr(32'h0000_12A8);
        chk("R9 restore mask", 128'(reassert_bits), 128'(32'h0000_1288));
        chk("R9 log kept", 128'(fep_ptr), 5);
        @(negedge clk);
        chk("R12 reassert single pulse", 128'(reassert_bits), 0);

        swr(32'h0000_1288);
        chk("R7 pop oldest", 128'(fep_ptr), 9);
        chk("R7 reassert all queued", 128'(reassert_bits), 128'(32'h0000_1288));
        swr(32'h0000_1088);
        chk("R7 fifo order", 128'(fep_ptr), 12);
        chk("R7 reassert after pop", 128'(reassert_bits), 128'(32'h0000_1088));

        // R11: simultaneous request and status write
        uncor_sts = 32'h0000_1088; sts_wr = 1;
        log_req = 1; log_status = 32'h2; log_hdr_valid = 1;
        @(negedge clk);
        sts_wr = 0; log_req = 0;
        chk("R11 request ignored ptr", 128'(fep_ptr), 12);
        chk("R11 no overflow", 128'(overflow), 0);
        chk("R11 remaining queue", 128'(reassert_bits), 128'(32'h0000_0088));

        mhr_en = 0;
        swr(32'h0000_1088);
        chk("R10 flush keeps log", 128'(fep_ptr), 12);
        mhr_en = 1;
        swr(32'h0000_0088);
        chk("R10 nothing replayed", 128'(fep_ptr), 0);
        chk("R8 header cleared", hdr_log, 0);
        chk("R8 prefix cleared", {pfx_log[126:0], pfx_flag}, 0);

        mhr_en = 0; pfx_supported = 0; uncor_sts = 32'h1;
        req(14, 0, 1, {4{32'hFFFF0000}}, {4{32'h55AA55AA}});
        chk("R5 disabled logs directly", 128'(fep_ptr), 14);
        chk("R3 invalid header zero", hdr_log, 0);
        chk("R4 unsupported prefix", {pfx_log[126:0], pfx_flag}, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule